// File: doc/BRIEF.md
# Multi-Buffer Byte Stream Port

This block is the device side of an 8-bit synchronous streaming port. An external application uses it to move bytes into or out of one of eight internal buffers. A 3-bit address picks the buffer. Half of the buffers are read buffers: the surrounding link logic fills them and the application empties them. The other half are write buffers: the application fills them and the link logic empties them. All buffers are 16-entry byte FIFOs.

The application first sets the address and the direction. It must hold them steady for two clock edges, and only after that may it raise enable. On a read, the block shows the next byte together with a data-available flag, starting one clock after an enabled edge. On a write, the block takes the write data on every enabled edge. A sync strobe marks the first byte of each burst. A write into a full buffer is discarded and sets an overflow flag for that buffer, and the flag stays set. The link side has a simple push port for the read buffers and a pop port for the write buffers.

Top module: `mbs_port`

## Requirements
- R1: Address bit 2 selects the buffer kind. Addresses 0 to 3 (bit 2 = 0) are read buffers and addresses 4 to 7 (bit 2 = 1) are write buffers. The two low address bits give the buffer index, and that index matches `fill_sel` for read buffers and `drain_sel` for write buffers.
- R2: No byte moves on an enabled edge unless `port_addr` and `port_rd` held the same value at the two rising edges before it. Any change of address or direction restarts that count. An enable raised earlier has no effect until the count is met.
- R3: `port_rd` = 1 means read. After a rising edge that samples enable high, a satisfied setup, a read buffer address and a non-empty buffer, the next cycle shows `port_av` = 1, `port_rdata` = the oldest byte of that buffer, and `port_sync` = 1 if this is the first byte of the burst. Each such edge removes one byte.
- R4: `port_av` falls in the cycle after the addressed read buffer runs empty. Whenever `port_av` is 0, `port_rdata` is 0.
- R5: `port_sync` is high for exactly one cycle per burst, on its first byte. A burst ends when enable is seen low or the setup is lost.
- R6: `port_rd` = 0 means write. Each rising edge that samples enable high, a satisfied setup and a write buffer address stores `port_wdata` in that buffer. `port_sync` is high in the same cycle as the first enabled write byte.
- R7: A write directed at a read buffer address, and a read directed at a write buffer address, change no buffer and never raise `port_av`.
- R8: A write into a full write buffer is discarded. It sets bit `index` of `ovf_flags`, and that bit stays set until reset.
- R9: Every buffer is first-in first-out with 16 entries. A link push into a full read buffer is discarded.
- R10: After reset, `port_av`, `port_sync`, `port_rdata`, `ovf_flags` and `drain_vld` are all 0, and every buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 3 | Buffer select from the application |
| port_rd | input | 1 | Direction: 1 read, 0 write |
| port_en | input | 1 | Transfer enable from the application |
| port_wdata | input | 8 | Write byte from the application |
| port_av | output | 1 | Read byte valid on `port_rdata` |
| port_sync | output | 1 | First byte of a burst |
| port_rdata | output | 8 | Read byte to the application |
| fill_en | input | 1 | Link push into a read buffer |
| fill_sel | input | 2 | Read buffer index for the push |
| fill_data | input | 8 | Byte pushed by the link |
| drain_en | input | 1 | Link pop from a write buffer |
| drain_sel | input | 2 | Write buffer index for the pop and the head view |
| drain_data | output | 8 | Head byte of the selected write buffer |
| drain_vld | output | 4 | Per write buffer: not empty |
| ovf_flags | output | 4 | Sticky per write buffer overflow flags |

## Verification
The setup and data-available properties assume that the application changes `port_addr`, `port_rd` and `port_en` only between clock edges. They also assume that a read byte can be linked to the inputs sampled exactly one edge earlier. The bench drives every application and link input on the falling edge, so each value is stable across the rising edge that samples it. The bench never changes direction in the middle of a burst without first dropping enable. Write-side sync checks sample shortly after the falling-edge drive, because that strobe follows enable within the same cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_BUF  = 1 << ADDR_W;
    localparam int NUM_RD   = NUM_BUF / 2;
    localparam int SEL_W    = ADDR_W - 1;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_SETUP = 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } access_t;

    typedef struct packed {
        logic  vld;
        logic  first;
        byte_t data;
    } rd_beat_t;

    // upper address bit marks the write half of the buffer bank
    function automatic logic is_wr_buf(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic sel_t buf_sel(input logic [ADDR_W-1:0] a);
        return a[SEL_W-1:0];
    endfunction

endpackage

// File: rtl/mbs_fifo.sv
module mbs_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W:0]   wp, rp;
    logic             do_push, do_pop;

    assign empty   = (wp == rp);
    assign full    = (wp[PTR_W] != rp[PTR_W]) && (wp[PTR_W-1:0] == rp[PTR_W-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[PTR_W-1:0]] <= din;
    end

endmodule

// File: rtl/mbs_setup_gate.sv
module mbs_setup_gate
    import mbs_pkg::*;
#(
    parameter int SETUP_CYC = DEF_SETUP
) (
    input  logic    clk,
    input  logic    rst,
    input  access_t cur,
    output logic    setup_ok
);
    localparam int CNT_W = $clog2(SETUP_CYC + 1);

    access_t          prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else if (cur != prev_q) begin
            prev_q <= cur;
            cnt_q  <= CNT_W'(1);
        end else if (cnt_q != CNT_W'(SETUP_CYC)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign setup_ok = (cur == prev_q) && (cnt_q == CNT_W'(SETUP_CYC));

endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  setup_ok,
    input  logic  rd_fire,
    input  logic  wr_fire,
    input  byte_t rd_byte,
    output logic  av,
    output logic  sync,
    output byte_t rdata
);
    logic     burst_q;
    rd_beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q <= 1'b0;
        end else if (!en || !setup_ok) begin
            burst_q <= 1'b0;
        end else if (rd_fire || wr_fire) begin
            burst_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.vld   <= rd_fire;
            beat_q.first <= rd_fire && !burst_q;
            beat_q.data  <= rd_fire ? rd_byte : '0;
        end
    end

    assign av    = beat_q.vld;
    assign rdata = beat_q.data;
    // read first-byte marker is registered; write marker follows enable in-cycle
    assign sync  = beat_q.first | (wr_fire && !burst_q);

endmodule

// File: rtl/mbs_port.sv
module mbs_port
    import mbs_pkg::*;
#(
    parameter int FIFO_DEPTH = DEF_DEPTH,
    parameter int SETUP_CYC  = DEF_SETUP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              port_rd,
    input  logic              port_en,
    input  logic [DATA_W-1:0] port_wdata,
    output logic              port_av,
    output logic              port_sync,
    output logic [DATA_W-1:0] port_rdata,
    input  logic              fill_en,
    input  logic [SEL_W-1:0]  fill_sel,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              drain_en,
    input  logic [SEL_W-1:0]  drain_sel,
    output logic [DATA_W-1:0] drain_data,
    output logic [NUM_RD-1:0] drain_vld,
    output logic [NUM_RD-1:0] ovf_flags
);
    access_t cur;
    dir_e    dir;
    sel_t    sel;
    logic    wr_side;
    logic    setup_ok;
    logic    rd_fire, wr_fire;

    byte_t             rd_head [NUM_RD];
    byte_t             wr_head [NUM_RD];
    logic [NUM_RD-1:0] rd_empty, rd_full;
    logic [NUM_RD-1:0] wr_empty, wr_full;
    logic [NUM_RD-1:0] ovf_set;
    logic [NUM_RD-1:0] ovf_q;

    assign cur     = '{addr: port_addr, rd: port_rd};
    assign dir     = dir_e'(port_rd);
    assign sel     = buf_sel(port_addr);
    assign wr_side = is_wr_buf(port_addr);

    mbs_setup_gate #(.SETUP_CYC(SETUP_CYC)) setup_i (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .setup_ok (setup_ok)
    );

    assign rd_fire = port_en && setup_ok && (dir == DIR_READ) && !wr_side && !rd_empty[sel];
    assign wr_fire = port_en && setup_ok && (dir == DIR_WRITE) && wr_side;

    for (genvar g = 0; g < NUM_RD; g++) begin : g_lane
        mbs_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rd_buf_i (
            .clk   (clk),
            .rst   (rst),
            .push  (fill_en && (fill_sel == sel_t'(g))),
            .pop   (rd_fire && (sel == sel_t'(g))),
            .din   (fill_data),
            .dout  (rd_head[g]),
            .full  (rd_full[g]),
            .empty (rd_empty[g])
        );

        mbs_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) wr_buf_i (
            .clk   (clk),
            .rst   (rst),
            .push  (wr_fire && (sel == sel_t'(g))),
            .pop   (drain_en && (drain_sel == sel_t'(g))),
            .din   (port_wdata),
            .dout  (wr_head[g]),
            .full  (wr_full[g]),
            .empty (wr_empty[g])
        );

        assign ovf_set[g] = wr_fire && (sel == sel_t'(g)) && wr_full[g];
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= '0;
        else     ovf_q <= ovf_q | ovf_set;
    end

    mbs_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .en       (port_en),
        .setup_ok (setup_ok),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire),
        .rd_byte  (rd_head[sel]),
        .av       (port_av),
        .sync     (port_sync),
        .rdata    (port_rdata)
    );

    assign drain_data = wr_head[drain_sel];
    assign drain_vld  = ~wr_empty;
    assign ovf_flags  = ovf_q;

    // read buffer fullness only gates the link push inside the FIFO
    logic unused_full;
    assign unused_full = ^rd_full;

endmodule

// File: rtl/mbs_port_chk.sv
module mbs_port_chk
    import mbs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] port_addr,
    input logic              port_rd,
    input logic              port_en,
    input logic              port_av,
    input logic              port_sync,
    input logic [DATA_W-1:0] port_rdata,
    input logic [NUM_RD-1:0] ovf_flags
);
    // R3 / R7: a read byte only follows an enabled read of the read half
    p_av_source_r3: assert property (@(posedge clk) disable iff (rst)
        port_av |-> ($past(port_en) && $past(port_rd) && !$past(port_addr[ADDR_W-1])));

    // R2: read data needs address and direction steady over the setup window
    p_rd_setup_r2: assert property (@(posedge clk) disable iff (rst)
        port_av |-> ($past(port_addr, 1) == $past(port_addr, 2)) &&
                    ($past(port_addr, 2) == $past(port_addr, 3)) &&
                    ($past(port_rd, 1) == $past(port_rd, 3)) &&
                    ($past(port_rd, 2) == $past(port_rd, 3)));

    // R2 / R6: a write burst start needs the same steadiness
    p_wr_setup_r2: assert property (@(posedge clk) disable iff (rst)
        (port_sync && !port_av) |-> (port_addr == $past(port_addr, 1)) &&
                                    (port_addr == $past(port_addr, 2)) &&
                                    (port_rd == $past(port_rd, 1)) &&
                                    (port_rd == $past(port_rd, 2)));

    // R6: a write-side sync only appears with an enabled write to the write half
    p_wr_sync_r6: assert property (@(posedge clk) disable iff (rst)
        (port_sync && !port_av) |-> (port_en && !port_rd && port_addr[ADDR_W-1]));

    // R5: sync never lasts two cycles
    p_sync_single_r5: assert property (@(posedge clk) disable iff (rst)
        port_sync |=> !port_sync);

    // R4: idle data bus is zero
    p_idle_data_r4: assert property (@(posedge clk) disable iff (rst)
        !port_av |-> (port_rdata == '0));

    // R8: overflow flags never clear outside reset
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

endmodule

bind mbs_port mbs_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .port_addr  (port_addr),
    .port_rd    (port_rd),
    .port_en    (port_en),
    .port_av    (port_av),
    .port_sync  (port_sync),
    .port_rdata (port_rdata),
    .ovf_flags  (ovf_flags)
);

// File: tb/mbs_port_tb_top.sv
module mbs_port_tb_top;
    import mbs_pkg::*;

    localparam int CLK_NS = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] port_addr = '0;
    logic              port_rd = 1'b0;
    logic              port_en = 1'b0;
    logic [DATA_W-1:0] port_wdata = '0;
    logic              port_av, port_sync;
    logic [DATA_W-1:0] port_rdata;
    logic              fill_en = 1'b0;
    logic [SEL_W-1:0]  fill_sel = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              drain_en = 1'b0;
    logic [SEL_W-1:0]  drain_sel = '0;
    logic [DATA_W-1:0] drain_data;
    logic [NUM_RD-1:0] drain_vld, ovf_flags;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    mbs_port dut_i (
        .clk        (clk),
        .rst        (rst),
        .port_addr  (port_addr),
        .port_rd    (port_rd),
        .port_en    (port_en),
        .port_wdata (port_wdata),
        .port_av    (port_av),
        .port_sync  (port_sync),
        .port_rdata (port_rdata),
        .fill_en    (fill_en),
        .fill_sel   (fill_sel),
        .fill_data  (fill_data),
        .drain_en   (drain_en),
        .drain_sel  (drain_sel),
        .drain_data (drain_data),
        .drain_vld  (drain_vld),
        .ovf_flags  (ovf_flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic fill(input int idx, input int b);
        @(negedge clk);
        fill_en = 1'b1; fill_sel = SEL_W'(idx); fill_data = DATA_W'(b);
        @(posedge clk); #1;
        fill_en = 1'b0;
    endtask

    task automatic drain(input int idx, output int b);
        @(negedge clk);
        drain_en = 1'b1; drain_sel = SEL_W'(idx);
        #2 b = int'(drain_data);
        @(posedge clk); #1;
        drain_en = 1'b0;
    endtask

    // returns at the falling edge where enable may first be raised
    task automatic select(input int a, input bit rd);
        @(negedge clk);
        port_addr = ADDR_W'(a); port_rd = rd; port_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_eq("R10 av after reset", int'(port_av), 0);
        chk_eq("R10 sync after reset", int'(port_sync), 0);
        chk_eq("R10 rdata after reset", int'(port_rdata), 0);
        chk_eq("R10 ovf after reset", int'(ovf_flags), 0);
        chk_eq("R10 drain_vld after reset", int'(drain_vld), 0);
    endtask

    task automatic t_read_basic();
        fill(2, 'hA1); fill(2, 'hA2); fill(2, 'hA3);
        select(2, 1'b1);
        port_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk_eq("R3 read av", int'(port_av), 1);
            chk_eq("R3 R9 read data order", int'(port_rdata), 'hA1 + k);
            chk_eq("R5 read sync on first only", int'(port_sync), (k == 0) ? 1 : 0);
        end
        @(negedge clk);
        chk_eq("R4 av drops when empty", int'(port_av), 0);
        chk_eq("R4 idle data zero", int'(port_rdata), 0);
        port_en = 1'b0;
    endtask

    task automatic t_early_enable();
        fill(1, 'hB0);
        @(negedge clk);
        port_addr = 3'd1; port_rd = 1'b1; port_en = 1'b1;
        @(negedge clk);
        chk_eq("R2 early enable ignored c1", int'(port_av), 0);
        @(negedge clk);
        chk_eq("R2 early enable ignored c2", int'(port_av), 0);
        @(negedge clk);
        chk_eq("R2 read after setup av", int'(port_av), 1);
        chk_eq("R2 R1 read after setup data", int'(port_rdata), 'hB0);
        chk_eq("R5 new burst sync", int'(port_sync), 1);
        port_en = 1'b0;
    endtask

    task automatic t_restart();
        fill(0, 'hC0);
        select(3, 1'b1);
        port_addr = 3'd0; port_en = 1'b1;
        @(negedge clk);
        chk_eq("R2 restart c1", int'(port_av), 0);
        port_addr = 3'd3;
        @(negedge clk);
        chk_eq("R2 restart c2", int'(port_av), 0);
        port_addr = 3'd0;
        @(negedge clk);
        chk_eq("R2 restart c3", int'(port_av), 0);
        @(negedge clk);
        chk_eq("R2 restart c4", int'(port_av), 0);
        @(negedge clk);
        chk_eq("R2 restart satisfied av", int'(port_av), 1);
        chk_eq("R2 restart satisfied data", int'(port_rdata), 'hC0);
        port_en = 1'b0;
    endtask

    task automatic t_write();
        int b;
        select(6, 1'b0);
        for (int k = 0; k < 3; k++) begin
            port_en = 1'b1; port_wdata = DATA_W'('h60 + k);
            #2;
            chk_eq("R6 write sync with first byte", int'(port_sync), (k == 0) ? 1 : 0);
            @(negedge clk);
        end
        port_en = 1'b0;
        chk_eq("R1 write lands in index 2", int'(drain_vld), 'b0100);
        for (int k = 0; k < 3; k++) begin
            drain(2, b);
            chk_eq("R6 R9 written byte order", b, 'h60 + k);
        end
        @(negedge clk);
        chk_eq("R6 write buffer drained", int'(drain_vld), 0);
    endtask

    task automatic t_wrong_direction();
        fill(1, 'hD0);
        select(1, 1'b0);
        port_en = 1'b1; port_wdata = 8'hEE;
        repeat (3) @(negedge clk);
        port_en = 1'b0;
        chk_eq("R7 write to read half stores nothing", int'(drain_vld), 0);
        select(1, 1'b1);
        port_en = 1'b1;
        @(negedge clk);
        chk_eq("R7 read half keeps its byte", int'(port_rdata), 'hD0);
        @(negedge clk);
        chk_eq("R7 read half had only one byte", int'(port_av), 0);
        port_en = 1'b0;
        select(6, 1'b0);
        port_en = 1'b1; port_wdata = 8'h77;
        @(negedge clk);
        port_en = 1'b0;
        select(6, 1'b1);
        port_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk_eq("R7 read of write half no av", int'(port_av), 0);
        end
        port_en = 1'b0;
        chk_eq("R7 write half byte kept", int'(drain_vld), 'b0100);
        begin
            int b;
            drain(2, b);
            chk_eq("R7 write half byte value", b, 'h77);
        end
    endtask

    task automatic t_overflow();
        int b;
        select(7, 1'b0);
        for (int k = 0; k < 17; k++) begin
            port_en = 1'b1; port_wdata = DATA_W'('h40 + k);
            if (k == 16) begin
                #2;
                chk_eq("R8 no overflow at 16 bytes", int'(ovf_flags), 0);
            end
            @(negedge clk);
        end
        port_en = 1'b0;
        chk_eq("R8 overflow flag bit 3", int'(ovf_flags), 'b1000);
        for (int k = 0; k < 16; k++) begin
            drain(3, b);
            chk_eq("R9 R8 kept bytes after overflow", b, 'h40 + k);
        end
        @(negedge clk);
        chk_eq("R9 16 entries only", int'(drain_vld), 0);
        chk_eq("R8 overflow stays set", int'(ovf_flags), 'b1000);
    endtask

    task automatic t_fill_full();
        for (int k = 0; k < 17; k++) fill(3, 'h90 + k);
        select(3, 1'b1);
        port_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk_eq("R9 read buffer byte", int'(port_rdata), 'h90 + k);
        end
        @(negedge clk);
        chk_eq("R9 extra link push dropped", int'(port_av), 0);
        port_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_basic();
        t_early_enable();
        t_restart();
        t_write();
        t_wrong_direction();
        t_overflow();
        t_fill_full();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule